// File: doc/BRIEF.md
# Frame-Scoped Write Protection Gate

This block sits between a network frame processor and a 64 KB slave memory map. It decides for every byte write whether the memory commits it or silently drops it. Two protection latches are kept. One guards the register area (addresses up to 0x0F7F). The other guards the whole map. Each latch has a matching enable bit that opens the gate only for the rest of the current frame.

The frame processor marks frame boundaries with single-cycle start and end pulses and presents byte writes as address, data and a request strobe. The block answers in the same cycle with a commit qualifier. Reads never pass through this gate. Two enable addresses stay writable under any protection, so a master can always open the gate. Every other write, including a write that clears a protection bit, is checked against the protection bits and the enable bits.

Top module: `wr_guard`

## Requirements
- R1: After reset, both protection bits and both enable bits are 0, and every write request is committed.
- R2: `wr_commit` is high only in a cycle where `wr_req` is high.
- R3: Writes to 0x0020 (register enable, data bit 0) and 0x0030 (memory-wide enable, data bit 0) are always committed and always update their enable bit.
- R4: A committed write to 0x0021 loads data bit 0 into the register protection bit. A committed write to 0x0031 loads data bit 0 into the memory-wide protection bit. Discarded writes to these addresses leave the bits unchanged.
- R5: While register protection is 1, a non-exempt write to 0x0000–0x0F7F commits only if the register enable bit is 1.
- R6: Under register protection alone, writes to 0x0F80–0xFFFF commit.
- R7: While memory-wide protection is 1, a non-exempt write to any address commits only if the memory-wide enable bit is 1.
- R8: When both protections are 1, a non-exempt register-area write needs both enable bits.
- R9: An enable write affects only later writes. A write in the same cycle is judged against the previous enable value.
- R10: A `frame_end` pulse clears both enable bits after that cycle. A write in the `frame_end` cycle is still judged with the current enables.
- R11: A `frame_start` pulse discards enables left from earlier frames. A write in that cycle is judged with both enables at 0. An enable write in that cycle takes effect for the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at frame start |
| frame_end | input | 1 | One-cycle pulse at frame end |
| wr_req | input | 1 | Byte write request |
| wr_addr | input | ADDR_W (16) | Byte address |
| wr_data | input | DATA_W (8) | Write data |
| wr_commit | output | 1 | High when the memory must commit the write |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit data and a register area ending at 0x0F7F. With these values, both edges of the register area (0x0F7F and 0x0F80), the start of process RAM (0x1000) and the top address 0xFFFF are all reachable. Directed frames cover every pairing of the two protection modes, enable writes placed on frame boundaries, and writes that share a cycle with an enable write. A long stretch of random traffic, biased toward the control addresses, then exercises mixed orderings against the reference model.

// File: rtl/wr_guard.sv
module wr_guard #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_EN_ADDR   = 16'h0020,
  parameter logic [ADDR_W-1:0] REG_PROT_ADDR = 16'h0021,
  parameter logic [ADDR_W-1:0] MEM_EN_ADDR   = 16'h0030,
  parameter logic [ADDR_W-1:0] MEM_PROT_ADDR = 16'h0031,
  parameter logic [ADDR_W-1:0] REG_TOP       = 16'h0F7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_commit
);

  logic reg_prot, mem_prot, reg_en, mem_en;
  logic reg_en_eff, mem_en_eff;
  logic hit_reg_en, hit_mem_en, exempt, in_reg;
  logic reg_ok, mem_ok;

  assign hit_reg_en = wr_req && (wr_addr == REG_EN_ADDR);
  assign hit_mem_en = wr_req && (wr_addr == MEM_EN_ADDR);
  assign exempt     = (wr_addr == REG_EN_ADDR) || (wr_addr == MEM_EN_ADDR);
  assign in_reg     = (wr_addr <= REG_TOP);

  assign reg_en_eff = reg_en & ~frame_start;
  assign mem_en_eff = mem_en & ~frame_start;

  assign reg_ok    = !reg_prot || !in_reg || reg_en_eff;
  assign mem_ok    = !mem_prot || mem_en_eff;
  assign wr_commit = wr_req && (exempt || (reg_ok && mem_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_en <= 1'b0;
      mem_en <= 1'b0;
    end else begin
      if (frame_end)        reg_en <= 1'b0;
      else if (hit_reg_en)  reg_en <= wr_data[0];
      else if (frame_start) reg_en <= 1'b0;

      if (frame_end)        mem_en <= 1'b0;
      else if (hit_mem_en)  mem_en <= wr_data[0];
      else if (frame_start) mem_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_prot <= 1'b0;
      mem_prot <= 1'b0;
    end else if (wr_commit) begin
      if (wr_addr == REG_PROT_ADDR) reg_prot <= wr_data[0];
      if (wr_addr == MEM_PROT_ADDR) mem_prot <= wr_data[0];
    end
  end

endmodule

module wr_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_commit,
  input logic              reg_prot,
  input logic              mem_prot,
  input logic              reg_en,
  input logic              mem_en
);

  a_r2_no_req_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> !wr_commit);

  a_r3_exempt_open: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && (wr_addr == 16'h0020 || wr_addr == 16'h0030) |-> wr_commit);

  a_r10_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !reg_en && !mem_en);

  a_r1_open_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !reg_prot && !mem_prot |-> wr_commit);

  a_r4_prot_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(reg_prot) && $stable(mem_prot));

  a_r7_mem_guard: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && mem_prot && !mem_en && wr_addr != 16'h0020 && wr_addr != 16'h0030
    |-> !wr_commit);

endmodule

bind wr_guard wr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .wr_req(wr_req),
  .wr_addr(wr_addr), .wr_commit(wr_commit), .reg_prot(reg_prot),
  .mem_prot(mem_prot), .reg_en(reg_en), .mem_en(mem_en)
);

// File: tb/sim_wr_guard.sv
`timescale 1ns/1ps
module sim_wr_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, frame_end = 1'b0, wr_req = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_commit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int m_rp = 0, m_mp = 0, m_re = 0, m_me = 0;

  always #2 clk = ~clk;

  wr_guard u0 (.clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_end(frame_end), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit));

  function automatic int expect_commit(int fs, int req, int a);
    int re, me;
    if (req == 0) return 0;
    if (a == 'h20 || a == 'h30) return 1;
    re = (fs != 0) ? 0 : m_re;
    me = (fs != 0) ? 0 : m_me;
    if (m_mp != 0 && me == 0) return 0;
    if (m_rp != 0 && a <= 'h0F7F && re == 0) return 0;
    return 1;
  endfunction

  task automatic cyc(input int fs, input int fe, input int req, input int a,
                     input int d, input string tag);
    int exp_c;
    @(negedge clk);
    frame_start = fs[0]; frame_end = fe[0]; wr_req = req[0];
    wr_addr = a[15:0]; wr_data = d[7:0];
    #1;
    exp_c = expect_commit(fs, req, a);
    n_cmp++;
    if (int'(wr_commit) != exp_c) begin
      n_bad++;
      $display("FAIL %s addr=%h: commit=%0d expected=%0d", tag, a[15:0], wr_commit, exp_c);
    end
    @(posedge clk);
    if (exp_c != 0 && a == 'h21) m_rp = d & 1;
    if (exp_c != 0 && a == 'h31) m_mp = d & 1;
    if (fe != 0) begin m_re = 0; m_me = 0; end
    else begin
      if (req != 0 && a == 'h20) m_re = d & 1; else if (fs != 0) m_re = 0;
      if (req != 0 && a == 'h30) m_me = d & 1; else if (fs != 0) m_me = 0;
    end
  endtask

  task automatic wr(input int a, input int d, input string tag);
    cyc(0, 0, 1, a, d, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, "R1 idle after reset R2");
    wr('h0100, 1, "R1 open register write");
    wr('h0021, 1, "R4 set reg protection");
    wr('h0100, 5, "R5 blocked register");
    wr('h0F7F, 5, "R5 top of register area");
    wr('h0F80, 5, "R6 user RAM open");
    wr('h1000, 5, "R6 process RAM open");
    wr('hFFFF, 5, "R6 top address");
    cyc(1, 0, 1, 'h0020, 1, "R11 enable on start beat");
    wr('h0100, 1, "R9 enabled register write");
    cyc(0, 1, 1, 'h0200, 1, "R10 write on end beat");
    wr('h0100, 1, "R10 enable gone after end");
    wr('h0020, 1, "R3 enable outside frame");
    cyc(1, 0, 1, 'h0100, 1, "R11 stale enable dropped");
    cyc(0, 0, 1, 'h0020, 1, "R9 enable beat");
    wr('h0031, 1, "R4 set mem protection");
    cyc(0, 1, 0, 0, 0, "R10 close frame");
    wr('h2000, 1, "R7 mem blocked");
    wr('h0021, 0, "R4 clear reg prot blocked");
    cyc(1, 0, 1, 'h0030, 1, "R3 mem enable");
    wr('h0100, 1, "R8 needs both");
    wr('h2000, 1, "R7 mem enabled");
    wr('h0020, 1, "R3 reg enable");
    wr('h0100, 1, "R8 both set");
    wr('h0031, 0, "R4 clear mem prot");
    wr('h0021, 0, "R4 clear reg prot");
    cyc(0, 1, 0, 0, 0, "R10 close");
    wr('h0100, 1, "R1 open again");
    for (int i = 0; i < 4000; i++) begin
      int sel, a;
      sel = $urandom_range(0, 9);
      case (sel)
        0: a = 'h20; 1: a = 'h21; 2: a = 'h30; 3: a = 'h31;
        4: a = 'h0F7F; 5: a = 'h0F80;
        default: a = $urandom_range(0, 'hFFFF);
      endcase
      cyc(($urandom_range(0, 7) == 0) ? 1 : 0, ($urandom_range(0, 7) == 0) ? 1 : 0,
          ($urandom_range(0, 3) != 0) ? 1 : 0, a, $urandom_range(0, 255),
          "R5 R7 R8 R9 random mix");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); n_bad++; $display("FAIL watchdog"); end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule